// File: doc/BRIEF.md
# Event-Triggered Register Microsequencer

This block is a small controller that wakes on a rising edge of one of its event inputs and executes a short stored program. Each program is up to eight instructions long and runs at one instruction per clock. The instructions move, add or subtract 32-bit values between four general registers and three external counters. The counters themselves live outside the block. The block reads their current values and modes, and it offers each of them a one-cycle load strobe carrying the data to load.

A counter that is busy counting or shifting cannot be overwritten. The block still reports the attempt on a per-counter strobe, but it raises that counter's load strobe only when the counter's mode is load or none. Arithmetic results may only land in general registers. An ADD or SUB that names a counter as its destination changes nothing.

Registers and programs are filled through a plain write port while the sequencer is idle. Events that arrive while a program runs are remembered and then served lowest index first. The four general registers are visible on a debug output.

Top module: `evt_microseq`

## Requirements
- R1: An instruction byte has opcode in bits [7:6] (00 MOV, 01 ADD, 10 SUB, 11 END), source in [5:3] and destination in [2:0]. Operand codes 0..3 are R0..R3, 4..6 are C0..C2, and source code 7 reads zero. MOV copies the source value into a register destination.
- R2: ADD writes dest+src into a register destination, modulo 2^32.
- R3: SUB writes dest−src into a register destination, modulo 2^32.
- R4: A counter operand used as source supplies that counter's present value from `cnt_val` (C0 in bits [31:0], C1 in [63:32], C2 in [95:64]).
- R5: A MOV to counter Cn raises `cnt_try[n]` for one cycle, with the value on `cnt_data`, in the cycle after it executes. It also raises `cnt_load[n]` in that cycle when the counter's mode code `cnt_mode[3n+2:3n]` is 0 (none) or 1 (load).
- R6: When that mode code is 2 (add), 3 (subtract), 4 (shift left) or 5 (shift right), `cnt_try[n]` still pulses, but `cnt_load[n]` stays low and the counter keeps its value.
- R7: ADD or SUB with a counter destination changes no register and raises no counter strobe.
- R8: A program starts only on a 0→1 transition of `evt_in[k]`. Holding the input high does not start it again, and a falling edge does not start it.
- R9: A program stops after its END instruction, which takes one busy cycle, or after its eighth instruction. `busy` is high for exactly one cycle per instruction executed.
- R10: An event that arrives while a program runs is held pending. Pending events are served one at a time, lowest index first.
- R11: A write on the preload port is ignored while `busy` is high. When idle, `cfg_prog`=0 writes register `cfg_addr[1:0]`, and `cfg_prog`=1 writes program byte `cfg_wdata[7:0]` at address {slot, step}, with the step in `cfg_addr[2:0]`.
- R12: Reset clears all registers, strobes and pending events, and fills every program byte with END.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 4 | Event inputs, one per program slot |
| cfg_we | input | 1 | Preload write enable |
| cfg_prog | input | 1 | 1 selects program store, 0 selects registers |
| cfg_addr | input | 5 | Preload address ({slot, step} or register index) |
| cfg_wdata | input | 32 | Preload data |
| cnt_val | input | 96 | Current values of C0..C2 |
| cnt_mode | input | 9 | Mode codes of C0..C2, 3 bits each |
| cnt_try | output | 3 | Per-counter write-attempt strobe |
| cnt_load | output | 3 | Per-counter accepted-load strobe |
| cnt_data | output | 32 | Data offered with the strobes |
| busy | output | 1 | A program is executing |
| dbg_regs | output | 128 | R0..R3, R0 in the low word |

## Verification
The bench uses the default parameters. A 32-bit data path lets it test wrap-around of ADD and SUB at 2^32. Four event slots give room to check priority among three events pending at once. With a depth of eight, a program that has no END can run to the full length, which checks the cutoff after the eighth instruction. A behavioural counter model in the bench applies accepted loads. Every counter mode code from 0 to 5 is driven, so both accepted and dropped writes are seen on the counters.

// File: rtl/evt_microseq.sv
module evt_microseq #(
  parameter int DATA_W     = 32,
  parameter int N_EVT      = 4,
  parameter int PROG_DEPTH = 8,
  localparam int SLOT_W = (N_EVT > 1) ? $clog2(N_EVT) : 1,
  localparam int PC_W   = (PROG_DEPTH > 2) ? $clog2(PROG_DEPTH) : 1,
  localparam int CFG_AW = SLOT_W + PC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_EVT-1:0]    evt_in,
  input  logic                cfg_we,
  input  logic                cfg_prog,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic [3*DATA_W-1:0] cnt_val,
  input  logic [8:0]          cnt_mode,
  output logic [2:0]          cnt_try,
  output logic [2:0]          cnt_load,
  output logic [DATA_W-1:0]   cnt_data,
  output logic                busy,
  output logic [4*DATA_W-1:0] dbg_regs
);

  localparam int PROG_SZ = 1 << CFG_AW;
  localparam logic [PC_W-1:0] LAST_PC = PC_W'(PROG_DEPTH - 1);
  localparam logic [1:0] OP_MOV = 2'b00, OP_ADD = 2'b01, OP_SUB = 2'b10, OP_END = 2'b11;

  logic [DATA_W-1:0] gpr [4];
  logic [7:0]        prog [PROG_SZ];
  logic [N_EVT-1:0]  evt_q, pend, pend_clr;
  logic [SLOT_W-1:0] slot, pick;
  logic [PC_W-1:0]   pc;

  wire [N_EVT-1:0] rise  = evt_in & ~evt_q;
  wire             start = !busy && (pend != '0);
  wire [7:0]       instr = prog[{slot, pc}];
  wire [1:0]       op    = instr[7:6];
  wire [2:0]       src   = instr[5:3];
  wire [2:0]       dst   = instr[2:0];
  wire             run   = busy && (op != OP_END);
  wire             to_reg = run && !dst[2];
  wire             to_cnt = busy && (op == OP_MOV) && dst[2] && (dst[1:0] != 2'b11);

  logic [DATA_W-1:0] src_val, dst_val, result;
  logic [2:0]        cnt_ok;

  always_comb begin
    case (src)
      3'd0, 3'd1, 3'd2, 3'd3: src_val = gpr[src[1:0]];
      3'd4:    src_val = cnt_val[0*DATA_W +: DATA_W];
      3'd5:    src_val = cnt_val[1*DATA_W +: DATA_W];
      3'd6:    src_val = cnt_val[2*DATA_W +: DATA_W];
      default: src_val = '0;
    endcase
    dst_val = gpr[dst[1:0]];
    case (op)
      OP_ADD:  result = dst_val + src_val;
      OP_SUB:  result = dst_val - src_val;
      default: result = src_val;
    endcase
  end

  always_comb begin
    pick = '0;
    for (int k = N_EVT - 1; k >= 0; k--)
      if (pend[k]) pick = SLOT_W'(k);
    pend_clr = start ? (N_EVT'(1) << pick) : '0;
  end

  for (genvar c = 0; c < 3; c++) begin : g_mode
    assign cnt_ok[c] = cnt_mode[3*c +: 3] <= 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
      pend  <= '0;
      busy  <= 1'b0;
      slot  <= '0;
      pc    <= '0;
      for (int r = 0; r < 4; r++) gpr[r] <= '0;
      for (int a = 0; a < PROG_SZ; a++) prog[a] <= {OP_END, 6'd0};
      cnt_try  <= '0;
      cnt_load <= '0;
      cnt_data <= '0;
    end else begin
      evt_q <= evt_in;
      pend  <= (pend & ~pend_clr) | rise;
      if (start) begin
        busy <= 1'b1;
        slot <= pick;
        pc   <= '0;
      end else if (busy) begin
        if (op == OP_END || pc == LAST_PC) busy <= 1'b0;
        else pc <= pc + 1'b1;
      end
      if (cfg_we && !busy) begin
        if (cfg_prog) prog[cfg_addr] <= cfg_wdata[7:0];
        else gpr[cfg_addr[1:0]] <= cfg_wdata;
      end
      if (to_reg) gpr[dst[1:0]] <= result;
      cnt_try  <= to_cnt ? (3'b001 << dst[1:0]) : 3'b000;
      cnt_load <= to_cnt ? ((3'b001 << dst[1:0]) & cnt_ok) : 3'b000;
      if (to_cnt) cnt_data <= src_val;
    end
  end

  assign dbg_regs = {gpr[3], gpr[2], gpr[1], gpr[0]};

  p_single_try_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_try));

  p_strobe_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_try != 3'b000) |-> $past(busy));

  p_idle_regs_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_we) |=> (dbg_regs == $past(dbg_regs)));

  p_pending_starts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pend != '0) |=> busy);

  for (genvar c = 0; c < 3; c++) begin : g_chk
    p_load_mode_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load[c] |-> (cnt_try[c] && ($past(cnt_mode[3*c +: 3]) <= 3'd1)));
    p_drop_in_count_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_try[c] && ($past(cnt_mode[3*c +: 3]) > 3'd1)) |-> !cnt_load[c]);
  end

endmodule

// File: tb/sim_evt_microseq.sv
module sim_evt_microseq;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  evt_in = '0;
  logic        cfg_we = 0, cfg_prog = 0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [95:0] cnt_val;
  logic [8:0]  cnt_mode = '0;
  logic [2:0]  cnt_try, cnt_load;
  logic [31:0] cnt_data;
  logic        busy;
  logic [127:0] dbg_regs;

  int errors = 0, checks = 0;
  int n_try[3], n_load[3];
  int busy_cyc = 0;
  logic [31:0] cv[3];
  logic [31:0] pv[3];
  logic        preset = 0;
  logic [7:0]  pb[8];

  always #(CLK_P/2) clk = ~clk;

  evt_microseq u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_we(cfg_we), .cfg_prog(cfg_prog),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cnt_val(cnt_val), .cnt_mode(cnt_mode),
    .cnt_try(cnt_try), .cnt_load(cnt_load), .cnt_data(cnt_data), .busy(busy),
    .dbg_regs(dbg_regs));

  assign cnt_val = {cv[2], cv[1], cv[0]};

  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (preset) cv[i] <= pv[i];
      else if (cnt_load[i]) cv[i] <= cnt_data;
      if (cnt_try[i]) n_try[i] = n_try[i] + 1;
      if (cnt_load[i]) n_load[i] = n_load[i] + 1;
    end
  end

  always @(negedge clk) if (busy) busy_cyc = busy_cyc + 1;

  function automatic logic [7:0] ins(input logic [1:0] op, input logic [2:0] s, input logic [2:0] d);
    return {op, s, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [31:0] rg(input int i);
    return dbg_regs[i*32 +: 32];
  endfunction

  task automatic wr_reg(input int r, input logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_prog = 0; cfg_addr = 5'(r); cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic put_prog(input int s);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); cfg_we = 1; cfg_prog = 1; cfg_addr = 5'(s*8 + k); cfg_wdata = {24'd0, pb[k]};
    end
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_cnt(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk); pv[0] = a; pv[1] = b; pv[2] = c; preset = 1;
    @(negedge clk); preset = 0;
  endtask

  task automatic wait_idle;
    int quiet = 0;
    for (int n = 0; n < 200 && quiet < 3; n++) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic clr_stats;
    busy_cyc = 0;
    for (int i = 0; i < 3; i++) begin n_try[i] = 0; n_load[i] = 0; end
  endtask

  task automatic fire(input logic [3:0] m);
    clr_stats();
    @(negedge clk); evt_in = m;
    @(negedge clk); evt_in = '0;
    wait_idle();
  endtask

  task automatic t_reset;
    check("R12 regs cleared", dbg_regs[31:0] | dbg_regs[63:32] | dbg_regs[95:64] | dbg_regs[127:96], 32'd0);
    check("R12 idle", {31'd0, busy}, 32'd0);
    check("R12 strobes", {26'd0, cnt_try, cnt_load}, 32'd0);
    fire(4'b0100);
    check("R12 END-filled program busy", busy_cyc, 1);
    check("R12 regs untouched", rg(0), 32'd0);
  endtask

  task automatic t_arith;
    wr_reg(1, 32'hFFFF_FFF0); wr_reg(2, 32'h20); wr_reg(3, 32'h5);
    pb = '{ins(0,1,0), ins(1,2,0), ins(2,2,3), ins(0,3,2), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0)};
    put_prog(0);
    fire(4'b0001);
    check("R2 add wraps", rg(0), 32'h10);
    check("R3 sub wraps", rg(3), 32'hFFFF_FFE5);
    check("R1 mov reg", rg(2), 32'hFFFF_FFE5);
    check("R1 source kept", rg(1), 32'hFFFF_FFF0);
    check("R9 end stops", busy_cyc, 5);
  endtask

  task automatic t_cnt_src;
    set_cnt(32'h11, 32'h22, 32'h33);
    pb = '{ins(0,6,2), ins(0,4,1), ins(0,7,3), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0)};
    put_prog(1);
    fire(4'b0010);
    check("R4 C2 source", rg(2), 32'h33);
    check("R4 C0 source", rg(1), 32'h11);
    check("R1 code7 reads zero", rg(3), 32'h0);
  endtask

  task automatic t_cnt_dst;
    set_cnt(32'h11, 32'h22, 32'h33);
    wr_reg(3, 32'hABCD);
    pb = '{ins(0,3,4), ins(0,3,5), ins(0,3,6), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0)};
    put_prog(1);
    cnt_mode = {3'd0, 3'd4, 3'd1};
    fire(4'b0010);
    check("R5 C0 load mode", cv[0], 32'hABCD);
    check("R6 C1 shift-left keeps", cv[1], 32'h22);
    check("R5 C2 none mode", cv[2], 32'hABCD);
    check("R5 tries", n_try[0] + n_try[1] + n_try[2], 3);
    check("R6 C1 no load", n_load[1], 0);
    set_cnt(32'h11, 32'h22, 32'h33);
    cnt_mode = {3'd5, 3'd3, 3'd2};
    fire(4'b0010);
    check("R6 add/sub/shr keep", {cv[0][7:0], cv[1][7:0], cv[2][7:0]}, 32'h112233);
    check("R6 tries still pulse", n_try[0] + n_try[1] + n_try[2], 3);
    check("R6 no loads", n_load[0] + n_load[1] + n_load[2], 0);
    cnt_mode = '0;
  endtask

  task automatic t_addsub_cnt;
    set_cnt(32'h11, 32'h22, 32'h33);
    wr_reg(0, 32'h7);
    pb = '{ins(1,0,4), ins(2,0,5), ins(1,0,6), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0)};
    put_prog(1);
    fire(4'b0010);
    check("R7 no strobes", n_try[0] + n_try[1] + n_try[2], 0);
    check("R7 counters kept", cv[0], 32'h11);
    check("R7 regs kept", rg(0), 32'h7);
  endtask

  task automatic t_level;
    wr_reg(0, 32'd10); wr_reg(1, 32'd3);
    pb = '{ins(1,1,0), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0)};
    put_prog(0);
    clr_stats();
    @(negedge clk); evt_in = 4'b0001;
    repeat (20) @(negedge clk);
    evt_in = '0;
    wait_idle();
    check("R8 one start for held level", rg(0), 32'd13);
    check("R8 busy cycles", busy_cyc, 2);
  endtask

  task automatic t_depth;
    wr_reg(1, 32'd4); wr_reg(3, 32'd0);
    for (int k = 0; k < 8; k++) pb[k] = ins(1,1,3);
    put_prog(1);
    fire(4'b0010);
    check("R9 eight instructions", rg(3), 32'd32);
    check("R9 busy length", busy_cyc, 8);
  endtask

  task automatic t_priority;
    wr_reg(0, 0); wr_reg(1, 5); wr_reg(2, 7);
    for (int k = 0; k < 8; k++) pb[k] = ins(0,3,3);
    put_prog(2);
    pb = '{ins(1,2,0), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0), ins(3,0,0)};
    put_prog(0);
    pb[0] = ins(0,1,0);
    put_prog(3);
    clr_stats();
    @(negedge clk); evt_in = 4'b0100;
    @(negedge clk); evt_in = '0;
    @(negedge clk); evt_in = 4'b1001;
    cfg_we = 1; cfg_prog = 0; cfg_addr = 5'd1; cfg_wdata = 32'd99;
    @(negedge clk); evt_in = '0; cfg_we = 0;
    wait_idle();
    check("R10 lowest index first", rg(0), 32'd5);
    check("R11 write ignored while busy", rg(1), 32'd5);
    check("R10 all three served", busy_cyc, 12);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin cv[i] = '0; pv[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_arith();
    t_cnt_src();
    t_cnt_dst();
    t_addsub_cnt();
    t_level();
    t_depth();
    t_priority();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end
endmodule